// File: doc/BRIEF.md
# Microcoded Control Sequencer for a 16-bit Register Machine

This block is the control unit of a small 16-bit register machine. It owns the micro-step state and nothing else. Each cycle it drives the strobes for the datapath: memory request, read or write and address source; instruction-latch load; program-counter increment or load and its source; register-file read and write; special-register access; operand, temp and result latch loads; ALU function select; and status-bit updates. The datapath registers, the buses and the memory itself sit outside the block.

After reset the block runs a two-cycle power-up sequence and then loops. Each pass fetches an instruction word from code space and spends one cycle on dispatch. Dispatch looks at the six opcode bits from the instruction latch and at the zero, carry and supervisor flags. The block then plays the micro-steps for that instruction and returns to fetch.

A pending hardware interrupt, a software trap and an illegal opcode all enter one shared exception sequence. That sequence saves the PC through the context pointer and jumps through the handler address. A freeze request parks the sequencer until an interrupt arrives.

Top module: `useq_ctrl`

## Requirements
- R1: While reset is held, every output strobe is 0. After release, the block asserts `st_init` for one cycle. In the next cycle it asserts `pc_load` with `pc_src`=0 (fixed vector). In the cycle after that it starts a fetch.
- R2: A fetch takes three cycles. The first asserts `pc_inc`. The second asserts `mem_req` and `mem_code` with `mem_wr`=0 and `mem_asel`=0 (PC). The third asserts `ir_load`. One dispatch cycle with no strobes follows, and the instruction's first micro-step comes after it.
- R3: When `ir_op[5:4]`=10 and the sub-op `ir_op[3:0]` is 0000..1011, the instruction runs eight micro-steps. Step 1 reads field A. Step 2 loads the operand latch. Step 5 loads the result latch with `alu_fn`=sub-op, and `alu_add` is 1 only for sub-op 1011. Step 8 writes field B (`rf_sel`=1) from the result (`rf_wsrc`=0). `cflag_load` is asserted in step 8 only for sub-ops 0111..1011.
- R4: When `ir_op[5:4]`=10, sub-ops 1100..1111 enter the exception sequence as illegal.
- R5: When `ir_op[5:4]`=11, sub-op 0000 with zero, carry and supervisor all clear is a software trap. Every other code in this group is illegal.
- R6: When `ir_op[5:4]`=01, sub-op 0000 is a load-immediate. It increments the PC, then reads code space, then writes field A from memory (`rf_wsrc`=1). Every other sub-op in this group is illegal.
- R7: When `ir_op[5:4]`=00, sub-op 0000 (load) and sub-op 0001 (store) each read field B and load the temp latch. A load then reads data space at the temp address (`mem_asel`=1, `mem_code`=0) and writes field A from memory. A store instead writes memory at the temp address while it reads field A.
- R8: In group 00, sub-op 0101 loads the PC from the register (`pc_src`=1). Sub-op 0100 adds a register to the PC, and sub-op 0110 adds the immediate field to the PC. Both load the sum (`pc_src`=2), and in both the adder is fed from the PC (`alu_pc_op`).
- R9: Every exception has three steps. Step 1 asserts `st_ie_clr` together with exactly one cause strobe: `st_soft_set` for a trap, `st_soft_clr` for a hardware interrupt, or `st_ill_set` for an illegal opcode. Step 2 writes memory at the context-pointer address (`mem_asel`=2). Step 3 loads the PC from the handler address (`pc_src`=3).
- R10: In group 00, sub-op 0111 jumps like 0110 when carry is clear and is a no-op when carry is set. Sub-op 1001 behaves the same way on the zero flag. Sub-op 1000 with carry set and sub-op 1010 with zero set are no-ops; with that flag clear they are illegal. A no-op goes straight to fetch.
- R11: At dispatch, an active `irq` wins over everything and enters the exception as a hardware interrupt. Without `irq`, an active `flag_frz` enters a freeze state. That state asserts no strobes and holds until `irq` is seen, and then it enters the exception.
- R12: In group 00, sub-op 0011 is a special-register swap when supervisor is set and illegal when it is clear. The swap reads the special register into temp, then reads field B and writes it to the special register, then writes field B from temp (`rf_wsrc`=2).
- R13: In group 00, sub-ops 0010 and 1011..1111 are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ir_op | input | 6 | Opcode bits from the instruction latch: [5:4] group, [3:0] sub-op |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_sup | input | 1 | Supervisor flag |
| flag_frz | input | 1 | Freeze request |
| irq | input | 1 | Hardware interrupt pending |
| mem_req | output | 1 | Memory request, data on the following clock |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_code | output | 1 | Code-space access |
| mem_asel | output | 2 | Address source: 0 PC, 1 temp latch, 2 context pointer |
| ir_load | output | 1 | Load the instruction latch from read data |
| pc_inc | output | 1 | Increment the PC |
| pc_load | output | 1 | Load the PC |
| pc_src | output | 2 | PC source: 0 vector, 1 register, 2 result latch, 3 handler address |
| rf_rd | output | 1 | Register-file read |
| rf_wr | output | 1 | Register-file write |
| rf_sel | output | 1 | Register field: 0 field A, 1 field B |
| rf_wsrc | output | 2 | Write data: 0 result, 1 memory, 2 temp |
| sr_rd | output | 1 | Special-register read |
| sr_wr | output | 1 | Special-register write |
| tmp_load | output | 1 | Load the temp/address latch |
| opnd_load | output | 1 | Load the operand latch |
| opnd_imm | output | 1 | Operand latch takes the immediate field |
| res_load | output | 1 | Load the result latch |
| alu_pc_op | output | 1 | Second adder input is the PC |
| alu_add | output | 1 | Select the adder rather than the logic unit |
| alu_fn | output | 4 | Logic unit function |
| cflag_load | output | 1 | Load the carry flag |
| st_init | output | 1 | Power-up status: clear trap, enable, illegal and freeze bits, set supervisor |
| st_ie_clr | output | 1 | Clear interrupt enable |
| st_soft_set | output | 1 | Set the soft-interrupt bit |
| st_soft_clr | output | 1 | Clear the soft-interrupt bit |
| st_ill_set | output | 1 | Set the illegal bit |

## Verification
The assertions check on every cycle that a write never happens without a request, and that an instruction-latch load always follows a code read. They also check that carry loads happen only with a result write-back, that exactly one cause strobe accompanies each exception entry, that the context-pointer save comes before the handler jump, and that the freeze state holds and stays quiet. Only the bench scenarios can show which sequence each opcode and flag combination selects, and the step on which each strobe lands. Those include the conditional branches that become no-ops, the privilege split on the swap code, and interrupt priority over freeze.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int OP_W   = 6;
  localparam int SUB_W  = 4;
  localparam int STEP_W = 3;
  localparam int FN_W   = SUB_W;
  localparam int SEL_W  = 2;

  typedef enum logic [3:0] {
    ST_RESET, ST_FETCH, ST_DISP, ST_ALU, ST_LDI, ST_LOAD, ST_STORE,
    ST_SWAP, ST_JABS, ST_JREL, ST_JIMM, ST_EXC, ST_FREEZE
  } seq_e;

  typedef enum logic [1:0] {CZ_HW, CZ_SOFT, CZ_ILL} cause_e;

  localparam logic [SEL_W-1:0] PCS_VEC = 2'd0, PCS_REG = 2'd1, PCS_RES = 2'd2, PCS_HND = 2'd3;
  localparam logic [SEL_W-1:0] AS_PC = 2'd0, AS_TMP = 2'd1, AS_CTX = 2'd2;
  localparam logic [SEL_W-1:0] WS_RES = 2'd0, WS_MEM = 2'd1, WS_TMP = 2'd2;
  localparam logic [SUB_W-1:0] SUB_ADD = 4'b1011;
  localparam logic [SUB_W-1:0] SUB_CFIRST = 4'b0111;

  typedef struct packed {
    logic             mem_req;
    logic             mem_wr;
    logic             mem_code;
    logic [SEL_W-1:0] mem_asel;
    logic             ir_load;
    logic             pc_inc;
    logic             pc_load;
    logic [SEL_W-1:0] pc_src;
    logic             rf_rd;
    logic             rf_wr;
    logic             rf_sel;
    logic [SEL_W-1:0] rf_wsrc;
    logic             sr_rd;
    logic             sr_wr;
    logic             tmp_load;
    logic             opnd_load;
    logic             opnd_imm;
    logic             res_load;
    logic             alu_pc_op;
    logic             alu_add;
    logic [FN_W-1:0]  alu_fn;
    logic             cflag_load;
    logic             st_init;
    logic             st_ie_clr;
    logic             st_soft_set;
    logic             st_soft_clr;
    logic             st_ill_set;
  } ctl_t;

  function automatic logic [STEP_W-1:0] last_step(seq_e s);
    case (s)
      ST_RESET: return 3'd1;
      ST_FETCH: return 3'd2;
      ST_ALU:   return 3'd7;
      ST_LDI:   return 3'd2;
      ST_LOAD:  return 3'd3;
      ST_STORE: return 3'd2;
      ST_SWAP:  return 3'd4;
      ST_JABS:  return 3'd1;
      ST_JREL:  return 3'd3;
      ST_JIMM:  return 3'd2;
      ST_EXC:   return 3'd2;
      default:  return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            zf,
  input  logic            cf,
  input  logic            sf,
  input  logic            irq,
  input  logic            frz,
  output seq_e            tgt,
  output cause_e          cz
);
  logic [SUB_W-1:0] sub;
  logic [1:0]       grp;
  assign sub = op[SUB_W-1:0];
  assign grp = op[OP_W-1 -: 2];

  always_comb begin
    tgt = ST_EXC;
    cz  = CZ_ILL;
    if (irq) begin
      cz = CZ_HW;
    end else if (frz) begin
      tgt = ST_FREEZE;
    end else begin
      case (grp)
        2'b11: if (sub == '0 && !zf && !cf && !sf) cz = CZ_SOFT;
        2'b10: if (sub <= SUB_ADD) tgt = ST_ALU;
        2'b01: if (sub == '0) tgt = ST_LDI;
        default: begin
          case (sub)
            4'h0: tgt = ST_LOAD;
            4'h1: tgt = ST_STORE;
            4'h3: if (sf) tgt = ST_SWAP;
            4'h4: tgt = ST_JREL;
            4'h5: tgt = ST_JABS;
            4'h6: tgt = ST_JIMM;
            4'h7: tgt = cf ? ST_FETCH : ST_JIMM;
            4'h8: if (cf) tgt = ST_FETCH;
            4'h9: tgt = zf ? ST_FETCH : ST_JIMM;
            4'ha: if (zf) tgt = ST_FETCH;
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/useq_seq.sv
module useq_seq
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              srst_n,
  input  seq_e              tgt,
  input  cause_e            cz,
  input  logic              irq,
  output seq_e              cur,
  output logic [STEP_W-1:0] step,
  output cause_e            cause
);
  seq_e              nxt_st;
  logic [STEP_W-1:0] nxt_step;
  cause_e            nxt_cz;

  always_comb begin
    nxt_st   = cur;
    nxt_step = step + 1'b1;
    nxt_cz   = cause;
    case (cur)
      ST_DISP: begin
        nxt_st   = tgt;
        nxt_cz   = cz;
        nxt_step = '0;
      end
      ST_FREEZE: begin
        nxt_step = '0;
        if (irq) begin
          nxt_st = ST_EXC;
          nxt_cz = CZ_HW;
        end
      end
      default: begin
        if (step == last_step(cur)) begin
          nxt_step = '0;
          if (cur == ST_RESET)      nxt_st = ST_FETCH;
          else if (cur == ST_FETCH) nxt_st = ST_DISP;
          else                      nxt_st = ST_FETCH;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cur   <= ST_RESET;
      step  <= '0;
      cause <= CZ_HW;
    end else begin
      cur   <= nxt_st;
      step  <= nxt_step;
      cause <= nxt_cz;
    end
  end
endmodule

// File: rtl/useq_uop.sv
module useq_uop
  import useq_pkg::*;
(
  input  logic              en,
  input  seq_e              cur,
  input  logic [STEP_W-1:0] step,
  input  logic [SUB_W-1:0]  sub,
  input  cause_e            cause,
  output ctl_t              ctl
);
  always_comb begin
    ctl = '0;
    case (cur)
      ST_RESET: case (step)
        3'd0: ctl.st_init = 1'b1;
        3'd1: begin ctl.pc_load = 1'b1; ctl.pc_src = PCS_VEC; end
        default: ;
      endcase
      ST_FETCH, ST_LDI: case (step)
        3'd0: ctl.pc_inc = 1'b1;
        3'd1: begin ctl.mem_req = 1'b1; ctl.mem_code = 1'b1; ctl.mem_asel = AS_PC; end
        3'd2: begin
          if (cur == ST_FETCH) ctl.ir_load = 1'b1;
          else begin ctl.rf_wr = 1'b1; ctl.rf_wsrc = WS_MEM; end
        end
        default: ;
      endcase
      ST_ALU: begin
        ctl.alu_fn  = sub;
        ctl.alu_add = (sub == SUB_ADD);
        case (step)
          3'd0: ctl.rf_rd = 1'b1;
          3'd1: begin ctl.rf_rd = 1'b1; ctl.opnd_load = 1'b1; end
          3'd2, 3'd3: begin ctl.rf_rd = 1'b1; ctl.rf_sel = 1'b1; end
          3'd4: ctl.res_load = 1'b1;
          3'd7: begin
            ctl.rf_wr      = 1'b1;
            ctl.rf_sel     = 1'b1;
            ctl.rf_wsrc    = WS_RES;
            ctl.cflag_load = (sub >= SUB_CFIRST);
          end
          default: ;
        endcase
      end
      ST_LOAD, ST_STORE: case (step)
        3'd0: begin ctl.rf_rd = 1'b1; ctl.rf_sel = 1'b1; end
        3'd1: begin ctl.rf_rd = 1'b1; ctl.rf_sel = 1'b1; ctl.tmp_load = 1'b1; end
        3'd2: begin
          ctl.mem_req  = 1'b1;
          ctl.mem_asel = AS_TMP;
          if (cur == ST_STORE) begin ctl.mem_wr = 1'b1; ctl.rf_rd = 1'b1; end
        end
        3'd3: begin ctl.rf_wr = 1'b1; ctl.rf_wsrc = WS_MEM; end
        default: ;
      endcase
      ST_SWAP: case (step)
        3'd0: ctl.sr_rd = 1'b1;
        3'd1: begin ctl.sr_rd = 1'b1; ctl.tmp_load = 1'b1; end
        3'd2: begin ctl.rf_rd = 1'b1; ctl.rf_sel = 1'b1; end
        3'd3: begin ctl.rf_rd = 1'b1; ctl.rf_sel = 1'b1; ctl.sr_wr = 1'b1; end
        3'd4: begin ctl.rf_wr = 1'b1; ctl.rf_sel = 1'b1; ctl.rf_wsrc = WS_TMP; end
        default: ;
      endcase
      ST_JABS: begin
        ctl.rf_rd = 1'b1;
        if (step == 3'd1) begin ctl.pc_load = 1'b1; ctl.pc_src = PCS_REG; end
      end
      ST_JREL: case (step)
        3'd0: ctl.rf_rd = 1'b1;
        3'd1: begin ctl.rf_rd = 1'b1; ctl.opnd_load = 1'b1; end
        3'd2: begin ctl.res_load = 1'b1; ctl.alu_add = 1'b1; ctl.alu_pc_op = 1'b1; end
        3'd3: begin ctl.pc_load = 1'b1; ctl.pc_src = PCS_RES; end
        default: ;
      endcase
      ST_JIMM: case (step)
        3'd0: begin ctl.opnd_load = 1'b1; ctl.opnd_imm = 1'b1; end
        3'd1: begin ctl.res_load = 1'b1; ctl.alu_add = 1'b1; ctl.alu_pc_op = 1'b1; end
        3'd2: begin ctl.pc_load = 1'b1; ctl.pc_src = PCS_RES; end
        default: ;
      endcase
      ST_EXC: case (step)
        3'd0: begin
          ctl.st_ie_clr   = 1'b1;
          ctl.st_soft_set = (cause == CZ_SOFT);
          ctl.st_soft_clr = (cause == CZ_HW);
          ctl.st_ill_set  = (cause == CZ_ILL);
        end
        3'd1: begin ctl.mem_req = 1'b1; ctl.mem_wr = 1'b1; ctl.mem_asel = AS_CTX; end
        3'd2: begin ctl.pc_load = 1'b1; ctl.pc_src = PCS_HND; end
        default: ;
      endcase
      default: ;
    endcase
    if (!en) ctl = '0;
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] ir_op,
  input  logic       flag_z,
  input  logic       flag_c,
  input  logic       flag_sup,
  input  logic       flag_frz,
  input  logic       irq,
  output logic       mem_req,
  output logic       mem_wr,
  output logic       mem_code,
  output logic [1:0] mem_asel,
  output logic       ir_load,
  output logic       pc_inc,
  output logic       pc_load,
  output logic [1:0] pc_src,
  output logic       rf_rd,
  output logic       rf_wr,
  output logic       rf_sel,
  output logic [1:0] rf_wsrc,
  output logic       sr_rd,
  output logic       sr_wr,
  output logic       tmp_load,
  output logic       opnd_load,
  output logic       opnd_imm,
  output logic       res_load,
  output logic       alu_pc_op,
  output logic       alu_add,
  output logic [3:0] alu_fn,
  output logic       cflag_load,
  output logic       st_init,
  output logic       st_ie_clr,
  output logic       st_soft_set,
  output logic       st_soft_clr,
  output logic       st_ill_set
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign srst_n = sync_q[SYNC_STAGES-1];

  seq_e              disp_tgt;
  cause_e            disp_cz;
  seq_e              cur_st;
  logic [STEP_W-1:0] cur_step;
  cause_e            cur_cause;
  ctl_t              ctl;

  useq_dispatch disp_i (
    .op(ir_op), .zf(flag_z), .cf(flag_c), .sf(flag_sup),
    .irq(irq), .frz(flag_frz), .tgt(disp_tgt), .cz(disp_cz)
  );

  useq_seq seq_i (
    .clk(clk), .srst_n(srst_n), .tgt(disp_tgt), .cz(disp_cz), .irq(irq),
    .cur(cur_st), .step(cur_step), .cause(cur_cause)
  );

  useq_uop uop_i (
    .en(srst_n), .cur(cur_st), .step(cur_step), .sub(ir_op[SUB_W-1:0]),
    .cause(cur_cause), .ctl(ctl)
  );

  assign mem_req     = ctl.mem_req;
  assign mem_wr      = ctl.mem_wr;
  assign mem_code    = ctl.mem_code;
  assign mem_asel    = ctl.mem_asel;
  assign ir_load     = ctl.ir_load;
  assign pc_inc      = ctl.pc_inc;
  assign pc_load     = ctl.pc_load;
  assign pc_src      = ctl.pc_src;
  assign rf_rd       = ctl.rf_rd;
  assign rf_wr       = ctl.rf_wr;
  assign rf_sel      = ctl.rf_sel;
  assign rf_wsrc     = ctl.rf_wsrc;
  assign sr_rd       = ctl.sr_rd;
  assign sr_wr       = ctl.sr_wr;
  assign tmp_load    = ctl.tmp_load;
  assign opnd_load   = ctl.opnd_load;
  assign opnd_imm    = ctl.opnd_imm;
  assign res_load    = ctl.res_load;
  assign alu_pc_op   = ctl.alu_pc_op;
  assign alu_add     = ctl.alu_add;
  assign alu_fn      = ctl.alu_fn;
  assign cflag_load  = ctl.cflag_load;
  assign st_init     = ctl.st_init;
  assign st_ie_clr   = ctl.st_ie_clr;
  assign st_soft_set = ctl.st_soft_set;
  assign st_soft_clr = ctl.st_soft_clr;
  assign st_ill_set  = ctl.st_ill_set;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
  import useq_pkg::*;
(
  input logic       clk,
  input logic       srst_n,
  input logic       irq,
  input seq_e       cur,
  input logic       mem_req,
  input logic       mem_wr,
  input logic       mem_code,
  input logic [1:0] mem_asel,
  input logic       ir_load,
  input logic       pc_load,
  input logic [1:0] pc_src,
  input logic       rf_wr,
  input logic [1:0] rf_wsrc,
  input logic       cflag_load,
  input logic       st_init,
  input logic       st_soft_set,
  input logic       st_soft_clr,
  input logic       st_ill_set
);
  assert_wr_has_req_R7: assert property (@(posedge clk) disable iff (!srst_n)
    mem_wr |-> mem_req);

  assert_irload_after_code_read_R2: assert property (@(posedge clk) disable iff (!srst_n)
    ir_load |-> $past(mem_req && mem_code && !mem_wr));

  assert_carry_only_on_writeback_R3: assert property (@(posedge clk) disable iff (!srst_n)
    cflag_load |-> (rf_wr && rf_wsrc == WS_RES));

  assert_one_cause_R9: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({st_soft_set, st_soft_clr, st_ill_set, st_init}));

  assert_cause_then_save_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (st_soft_set || st_soft_clr || st_ill_set) |=> (mem_req && mem_wr && mem_asel == AS_CTX));

  assert_handler_after_save_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (pc_load && pc_src == PCS_HND) |-> $past(mem_wr && mem_asel == AS_CTX));

  assert_freeze_holds_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (cur == ST_FREEZE && !irq) |=> cur == ST_FREEZE);

  assert_freeze_quiet_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (cur == ST_FREEZE) |-> (!mem_req && !pc_load && !rf_wr));

  assert_vector_after_init_R1: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(st_init) |=> (pc_load && pc_src == PCS_VEC));
endmodule

bind useq_ctrl useq_ctrl_chk chk_i (
  .clk(clk), .srst_n(srst_n), .irq(irq), .cur(cur_st),
  .mem_req(mem_req), .mem_wr(mem_wr), .mem_code(mem_code), .mem_asel(mem_asel),
  .ir_load(ir_load), .pc_load(pc_load), .pc_src(pc_src), .rf_wr(rf_wr),
  .rf_wsrc(rf_wsrc), .cflag_load(cflag_load), .st_init(st_init),
  .st_soft_set(st_soft_set), .st_soft_clr(st_soft_clr), .st_ill_set(st_ill_set)
);

// File: tb/useq_ctrl_tb_top.sv
module useq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ir_op = '0;
  logic flag_z = 0, flag_c = 0, flag_sup = 0, flag_frz = 0, irq = 0;

  logic mem_req, mem_wr, mem_code, ir_load, pc_inc, pc_load, rf_rd, rf_wr, rf_sel;
  logic sr_rd, sr_wr, tmp_load, opnd_load, opnd_imm, res_load, alu_pc_op, alu_add, cflag_load;
  logic st_init, st_ie_clr, st_soft_set, st_soft_clr, st_ill_set;
  logic [1:0] mem_asel, pc_src, rf_wsrc;
  logic [3:0] alu_fn;

  always #2 clk = ~clk;

  useq_ctrl dut_i (.*);

  typedef struct packed {
    logic mem_req, mem_wr, mem_code; logic [1:0] mem_asel;
    logic ir_load, pc_inc, pc_load; logic [1:0] pc_src;
    logic rf_rd, rf_wr, rf_sel; logic [1:0] rf_wsrc;
    logic sr_rd, sr_wr, tmp_load, opnd_load, opnd_imm, res_load, alu_pc_op, alu_add;
    logic [3:0] alu_fn;
    logic cflag_load, st_init, st_ie_clr, st_soft_set, st_soft_clr, st_ill_set;
  } obs_t;

  localparam int TR = 12;
  obs_t tr [TR];
  int checks = 0;
  int failures = 0;

  function automatic obs_t sample();
    obs_t o;
    o = '{mem_req, mem_wr, mem_code, mem_asel, ir_load, pc_inc, pc_load, pc_src,
          rf_rd, rf_wr, rf_sel, rf_wsrc, sr_rd, sr_wr, tmp_load, opnd_load, opnd_imm,
          res_load, alu_pc_op, alu_add, alu_fn, cflag_load, st_init, st_ie_clr,
          st_soft_set, st_soft_clr, st_ill_set};
    return o;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_irload();
    int n = 0;
    do begin @(negedge clk); n++; end while (!ir_load && n < 60);
    chk("R2", "fetch reaches ir_load", int'(ir_load), 1);
  endtask

  task automatic run_op(input logic [5:0] op, input logic z, input logic c,
                        input logic s, input logic fr, input logic iq);
    wait_irload();
    ir_op = op; flag_z = z; flag_c = c; flag_sup = s; flag_frz = fr; irq = iq;
    for (int i = 0; i < TR; i++) begin
      @(negedge clk);
      tr[i] = sample();
    end
  endtask

  task automatic t_reset();
    int n = 0;
    repeat (3) @(negedge clk);
    chk("R1", "strobes quiet in reset", int'(sample() != '0), 0);
    rst_n = 1'b1;
    do begin @(negedge clk); n++; end while (!st_init && n < 10);
    chk("R1", "st_init after release", int'(st_init), 1);
    @(negedge clk);
    chk("R1", "vector pc_load", int'(pc_load), 1);
    chk("R1", "vector pc_src", int'(pc_src), 0);
    chk("R1", "st_init one cycle", int'(st_init), 0);
    @(negedge clk);
    chk("R2", "fetch pc_inc", int'(pc_inc), 1);
    @(negedge clk);
    chk("R2", "code read", int'({mem_req, mem_code, mem_wr, mem_asel}), 'b11000);
    @(negedge clk);
    chk("R2", "ir_load", int'(ir_load), 1);
    @(negedge clk);
    chk("R2", "dispatch cycle quiet", int'(sample() != '0), 0);
  endtask

  task automatic t_alu(input logic [3:0] sub, input logic exp_c);
    run_op({2'b10, sub}, 0, 0, 0, 0, 0);
    chk("R3", "dispatch quiet", int'(tr[0] != '0), 0);
    chk("R3", "step1 read A", int'({tr[1].rf_rd, tr[1].rf_sel}), 'b10);
    chk("R3", "step2 operand load", int'(tr[2].opnd_load), 1);
    chk("R3", "step5 result load", int'(tr[5].res_load), 1);
    chk("R3", "alu_fn", int'(tr[5].alu_fn), int'(sub));
    chk("R3", "alu_add", int'(tr[5].alu_add), int'(sub == 4'b1011));
    chk("R3", "no early write", int'(tr[7].rf_wr | tr[6].rf_wr), 0);
    chk("R3", "step8 write B from result",
        int'({tr[8].rf_wr, tr[8].rf_sel, tr[8].rf_wsrc}), 'b1100);
    chk("R3", "carry load", int'(tr[8].cflag_load), int'(exp_c));
    chk("R3", "back to fetch after 8", int'(tr[9].pc_inc), 1);
  endtask

  task automatic t_exc(input string req, input logic [5:0] op, input logic z,
                       input logic c, input logic s, input logic fr, input logic iq,
                       input int exp_cause);
    run_op(op, z, c, s, fr, iq);
    irq = 1'b0;
    flag_frz = 1'b0;
    chk(req, "R9 cause soft_set,soft_clr,ill_set",
        int'({tr[1].st_soft_set, tr[1].st_soft_clr, tr[1].st_ill_set}), exp_cause);
    chk(req, "R9 ie clear", int'(tr[1].st_ie_clr), 1);
    chk(req, "R9 save to context",
        int'({tr[2].mem_req, tr[2].mem_wr, tr[2].mem_asel}), 'b1110);
    chk(req, "R9 handler load", int'({tr[3].pc_load, tr[3].pc_src}), 'b111);
    chk(req, "R9 return to fetch", int'(tr[4].pc_inc), 1);
  endtask

  task automatic t_ldi();
    run_op(6'b010000, 0, 0, 0, 0, 0);
    chk("R6", "second increment", int'(tr[1].pc_inc), 1);
    chk("R6", "operand code read", int'({tr[2].mem_req, tr[2].mem_code, tr[2].mem_wr}), 'b110);
    chk("R6", "write A from memory", int'({tr[3].rf_wr, tr[3].rf_sel, tr[3].rf_wsrc}), 'b1001);
    chk("R6", "back to fetch", int'(tr[4].pc_inc), 1);
  endtask

  task automatic t_load_store();
    run_op(6'b000000, 0, 0, 0, 0, 0);
    chk("R7", "load reads B", int'({tr[1].rf_rd, tr[1].rf_sel}), 'b11);
    chk("R7", "load temp", int'(tr[2].tmp_load), 1);
    chk("R7", "load data read",
        int'({tr[3].mem_req, tr[3].mem_wr, tr[3].mem_code, tr[3].mem_asel}), 'b10001);
    chk("R7", "load write A from mem", int'({tr[4].rf_wr, tr[4].rf_sel, tr[4].rf_wsrc}), 'b1001);
    chk("R7", "load done", int'(tr[5].pc_inc), 1);
    run_op(6'b000001, 0, 0, 0, 0, 0);
    chk("R7", "store temp", int'(tr[2].tmp_load), 1);
    chk("R7", "store write",
        int'({tr[3].mem_req, tr[3].mem_wr, tr[3].mem_code, tr[3].mem_asel}), 'b11001);
    chk("R7", "store reads A", int'({tr[3].rf_rd, tr[3].rf_sel}), 'b10);
    chk("R7", "store no reg write", int'(tr[3].rf_wr), 0);
    chk("R7", "store done", int'(tr[4].pc_inc), 1);
  endtask

  task automatic t_jumps();
    run_op(6'b000101, 0, 0, 0, 0, 0);
    chk("R8", "abs pc_load from reg", int'({tr[2].pc_load, tr[2].pc_src}), 'b101);
    chk("R8", "abs done", int'(tr[3].pc_inc), 1);
    run_op(6'b000100, 0, 0, 0, 0, 0);
    chk("R8", "rel sum with pc", int'({tr[3].res_load, tr[3].alu_add, tr[3].alu_pc_op}), 'b111);
    chk("R8", "rel pc_load result", int'({tr[4].pc_load, tr[4].pc_src}), 'b110);
    run_op(6'b000110, 0, 0, 0, 0, 0);
    chk("R8", "imm operand", int'({tr[1].opnd_load, tr[1].opnd_imm}), 'b11);
    chk("R8", "imm pc_load result", int'({tr[3].pc_load, tr[3].pc_src}), 'b110);
    chk("R8", "imm done", int'(tr[4].pc_inc), 1);
  endtask

  task automatic t_cond_jump(input logic [5:0] op, input logic z, input logic c);
    run_op(op, z, c, 0, 0, 0);
    chk("R10", "taken pc_load result", int'({tr[3].pc_load, tr[3].pc_src}), 'b110);
  endtask

  task automatic t_noop(input logic [5:0] op, input logic z, input logic c);
    run_op(op, z, c, 0, 0, 0);
    chk("R10", "no-op fetch next", int'(tr[1].pc_inc), 1);
    chk("R10", "no-op no pc_load", int'(tr[1].pc_load | tr[2].pc_load | tr[3].pc_load), 0);
  endtask

  task automatic t_swap();
    run_op(6'b000011, 0, 0, 1, 0, 0);
    chk("R12", "sr read", int'(tr[1].sr_rd), 1);
    chk("R12", "temp from sr", int'({tr[2].sr_rd, tr[2].tmp_load}), 'b11);
    chk("R12", "sr write", int'({tr[4].sr_wr, tr[4].rf_rd, tr[4].rf_sel}), 'b111);
    chk("R12", "reg from temp", int'({tr[5].rf_wr, tr[5].rf_sel, tr[5].rf_wsrc}), 'b1110);
    chk("R12", "swap done", int'(tr[6].pc_inc), 1);
  endtask

  task automatic t_freeze();
    int busy = 0;
    run_op(6'b101011, 0, 0, 0, 1, 0);
    for (int i = 0; i < TR; i++) if (tr[i] != '0) busy++;
    chk("R11", "freeze quiet cycles with strobes", busy, 0);
    irq = 1'b1;
    @(negedge clk);
    chk("R11", "irq leaves freeze", int'({tr[0].st_soft_set, st_soft_clr, st_ie_clr}), 'b011);
    irq = 1'b0;
    flag_frz = 1'b0;
    @(negedge clk);
    chk("R11", "context save after freeze", int'({mem_req, mem_wr, mem_asel}), 'b1110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_alu(4'b0000, 0);
    t_alu(4'b0010, 0);
    t_alu(4'b0111, 1);
    t_alu(4'b1011, 1);
    t_exc("R4", 6'b101100, 0, 0, 0, 0, 0, 'b001);
    t_exc("R4", 6'b101111, 0, 0, 1, 0, 0, 'b001);
    t_exc("R5", 6'b110000, 0, 0, 0, 0, 0, 'b100);
    t_exc("R5", 6'b110000, 0, 1, 0, 0, 0, 'b001);
    t_exc("R5", 6'b110000, 0, 0, 1, 0, 0, 'b001);
    t_exc("R5", 6'b110101, 0, 0, 0, 0, 0, 'b001);
    t_ldi();
    t_exc("R6", 6'b010001, 0, 0, 0, 0, 0, 'b001);
    t_load_store();
    t_jumps();
    t_cond_jump(6'b000111, 0, 0);
    t_noop(6'b000111, 0, 1);
    t_noop(6'b001000, 0, 1);
    t_exc("R10", 6'b001000, 0, 0, 0, 0, 0, 'b001);
    t_cond_jump(6'b001001, 0, 0);
    t_noop(6'b001001, 1, 0);
    t_noop(6'b001010, 1, 0);
    t_exc("R10", 6'b001010, 0, 0, 0, 0, 0, 'b001);
    t_swap();
    t_exc("R12", 6'b000011, 0, 0, 0, 0, 0, 'b001);
    t_exc("R13", 6'b000010, 0, 0, 1, 0, 0, 'b001);
    t_exc("R13", 6'b001011, 0, 0, 0, 0, 0, 'b001);
    t_exc("R13", 6'b001111, 0, 0, 0, 0, 0, 'b001);
    t_exc("R11", 6'b101011, 0, 0, 0, 1, 1, 'b010);
    t_exc("R11", 6'b000000, 0, 0, 0, 0, 1, 'b010);
    t_freeze();
    t_alu(4'b0001, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule